// File: doc/BRIEF.md
# Linked-Descriptor Memory Copy Engine

This block copies data between two regions of one memory, following a chain of 32-byte descriptors that software has placed in that memory. Software writes the address of the first descriptor into the pointer register. It then writes the control register with the run bit set. The engine reads each descriptor, copies its payload one 32-bit word at a time, and writes the result back into the descriptor. It then moves on to the descriptor named in the next-address field. The chain ends at the first descriptor whose hardware-ownership flag is clear. It also ends, if software asked for a limit, once a given number of descriptors has been processed.

Completion of a descriptor and termination of the chain each set a sticky status flag. The interrupt line is the OR of the flags whose per-event enable is set. That OR is then qualified by a global interrupt enable, so the flags still set with the global enable off but the line stays low.

The memory master issues one single-beat access per cycle and expects read data on `mem_rdata` in the cycle after a read request. The register port is a write strobe plus an address, and `reg_rdata` shows the addressed register one cycle after the address is presented.

Top module: `sgd_engine`

## Requirements
- R1: After reset the status, control and pointer registers read 0, `irq` is 0, and no memory access is issued.
- R2: Registers are 32-bit words at byte offsets 0 (status), 16 (control) and 32 (pointer).
  - Status: bit 0 descriptor-done, bit 1 chain-done, bit 2 busy.
  - Control: bit 0 run, bit 1 descriptor-done interrupt enable, bit 2 chain-done interrupt enable, bit 3 global interrupt enable, bits 15:8 descriptor limit.
  - `reg_rdata` shows the register at `reg_addr` one cycle later.
- R3: A descriptor is eight words at a 32-byte aligned address.
  - Word offsets: +0 source, +4 destination, +8 next descriptor, +12 byte count (bits 15:0, a multiple of 4), +16 bytes actually moved, +20 flags.
  - Flags bit 0 is the owned-by-hardware bit.
- R4: For an owned descriptor with byte count N, the engine copies N/4 words in ascending order. Word i is read from source+4i and written to destination+4i. A zero count copies nothing.
- R5: After the copy, the engine writes the number of bytes moved to offset +16. It then writes the flags word to offset +20 with bit 0 cleared and all other bits unchanged. These are the only writes to the descriptor.
- R6: A fetched descriptor whose owned bit is 0 is neither copied nor written. The chain ends there, chain-done is set, and the pointer register is left holding that descriptor's address.
- R7: With a nonzero descriptor limit M, the chain ends after M descriptors have been processed, and chain-done is set. The pointer register then holds the next-descriptor address of the last one processed.
- R8: Descriptor-done is set after each processed descriptor. Writing 1 to a status flag bit clears it. A set event and a clear write in the same cycle leave the flag set.
- R9: One cycle after the condition holds, `irq` equals global-enable AND ((descriptor-done AND its enable) OR (chain-done AND its enable)). With the global enable at 0, `irq` stays 0 although the flags still set.
- R10: Busy is 1 from the cycle after a run write issued while idle until the chain ends. Pointer writes while busy are ignored, and no memory access occurs while not busy.
- R11: After each processed descriptor the pointer register takes that descriptor's next-descriptor address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read request |
| irq | output | 1 | Level interrupt |

## Verification
The engine setting descriptor-done can land in the same cycle as a software write-1-to-clear of that flag. The bench provokes this by watching the memory port for the flags write-back of a descriptor and issuing the clear write in that same cycle. It judges the result by reading status afterwards and expecting the flag still set. An ordinary clear issued in an idle cycle is also checked, so the two outcomes can be told apart.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_FRD, S_FCAP, S_CHECK, S_CRD, S_CWR, S_WBA, S_WBF
  } walk_st_t;

  localparam int unsigned FETCH_LAST = 5;   // last descriptor word fetched
  localparam logic [5:0]  OFS_STATUS = 6'd0;
  localparam logic [5:0]  OFS_CTRL   = 6'd16;
  localparam logic [5:0]  OFS_PTR    = 6'd32;
  localparam int unsigned DESC_ACT_OFS = 16;
  localparam int unsigned DESC_FLG_OFS = 20;
endpackage

// File: rtl/sgd_regs.sv
module sgd_regs #(
  parameter int unsigned AW   = 32,
  parameter int unsigned MAXW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            reg_we,
  input  logic [5:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            busy,
  input  logic            ev_desc,
  input  logic            ev_chain,
  input  logic            ptr_adv,
  input  logic [AW-1:0]   ptr_nxt,
  output logic            start,
  output logic [AW-1:0]   ptr_q,
  output logic [MAXW-1:0] max_q,
  output logic            gie_q,
  output logic            dd_q,
  output logic            cd_q,
  output logic            irq
);
  import sgd_pkg::*;

  logic run_q, ied_q, iec_q;
  logic wr_st, wr_ct, wr_pt;
  logic [31:0] rd_nx;

  assign wr_st = reg_we && (reg_addr == OFS_STATUS);
  assign wr_ct = reg_we && (reg_addr == OFS_CTRL);
  assign wr_pt = reg_we && (reg_addr == OFS_PTR);
  assign start = wr_ct && reg_wdata[0] && !busy;

  always_comb begin
    if (reg_addr == OFS_STATUS)    rd_nx = {29'd0, busy, cd_q, dd_q};
    else if (reg_addr == OFS_CTRL) rd_nx = 32'({max_q, 4'b0000, gie_q, iec_q, ied_q, run_q});
    else if (reg_addr == OFS_PTR)  rd_nx = 32'(ptr_q);
    else                           rd_nx = 32'd0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dd_q <= 1'b0; cd_q <= 1'b0;
      run_q <= 1'b0; ied_q <= 1'b0; iec_q <= 1'b0; gie_q <= 1'b0;
      max_q <= '0; ptr_q <= '0; irq <= 1'b0; reg_rdata <= '0;
    end else begin
      if (ev_desc)                    dd_q <= 1'b1;
      else if (wr_st && reg_wdata[0]) dd_q <= 1'b0;
      if (ev_chain)                   cd_q <= 1'b1;
      else if (wr_st && reg_wdata[1]) cd_q <= 1'b0;
      if (wr_ct) begin
        run_q <= reg_wdata[0];
        ied_q <= reg_wdata[1];
        iec_q <= reg_wdata[2];
        gie_q <= reg_wdata[3];
        max_q <= reg_wdata[8 +: MAXW];
      end
      if (ptr_adv)             ptr_q <= ptr_nxt;
      else if (wr_pt && !busy) ptr_q <= AW'(reg_wdata);
      irq       <= gie_q && ((ied_q && dd_q) || (iec_q && cd_q));
      reg_rdata <= rd_nx;
    end
  end
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker #(
  parameter int unsigned AW   = 32,
  parameter int unsigned LENW = 16,
  parameter int unsigned MAXW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [AW-1:0]   ptr_q,
  input  logic [MAXW-1:0] max_q,
  output logic            busy,
  output logic            ev_desc,
  output logic            ev_chain,
  output logic            ptr_adv,
  output logic [AW-1:0]   ptr_nxt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata
);
  import sgd_pkg::*;

  walk_st_t st;
  logic [AW-1:0]   cur, src, dst, nxt;
  logic [LENW-1:0] len, cnt, words;
  logic [31:0]     flg;
  logic [2:0]      idx;
  logic [MAXW-1:0] ndone;
  logic            limit_hit;

  assign words     = len >> 2;
  assign limit_hit = (max_q != '0) && ((ndone + MAXW'(1)) == max_q);
  assign busy      = (st != S_IDLE);
  assign ev_desc   = (st == S_WBF);
  assign ptr_adv   = (st == S_WBF);
  assign ptr_nxt   = nxt;
  assign ev_chain  = ((st == S_CHECK) && !flg[0]) || ((st == S_WBF) && limit_hit);

  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = '0; mem_wdata = '0;
    case (st)
      S_FRD: begin mem_req = 1'b1; mem_addr = cur + AW'({idx, 2'b00}); end
      S_CRD: begin mem_req = 1'b1; mem_addr = src + (AW'(cnt) << 2); end
      S_CWR: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = dst + (AW'(cnt) << 2); mem_wdata = mem_rdata;
      end
      S_WBA: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur + AW'(DESC_ACT_OFS); mem_wdata = 32'({cnt, 2'b00});
      end
      S_WBF: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = cur + AW'(DESC_FLG_OFS); mem_wdata = {flg[31:1], 1'b0};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; cur <= '0; src <= '0; dst <= '0; nxt <= '0;
      len <= '0; cnt <= '0; flg <= '0; idx <= '0; ndone <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur <= ptr_q; idx <= '0; ndone <= '0; st <= S_FRD;
        end
        S_FRD: st <= S_FCAP;
        S_FCAP: begin
          case (idx)
            3'd0: src <= AW'(mem_rdata);
            3'd1: dst <= AW'(mem_rdata);
            3'd2: nxt <= AW'(mem_rdata);
            3'd3: len <= mem_rdata[LENW-1:0];
            3'd5: flg <= mem_rdata;
            default: ;
          endcase
          if (idx == 3'(FETCH_LAST)) st <= S_CHECK;
          else begin idx <= idx + 3'd1; st <= S_FRD; end
        end
        S_CHECK: begin
          cnt <= '0;
          if (!flg[0])          st <= S_IDLE;
          else if (words == '0) st <= S_WBA;
          else                  st <= S_CRD;
        end
        S_CRD: st <= S_CWR;
        S_CWR: begin
          cnt <= cnt + LENW'(1);
          st  <= ((cnt + LENW'(1)) == words) ? S_WBA : S_CRD;
        end
        S_WBA: st <= S_WBF;
        S_WBF: begin
          ndone <= ndone + MAXW'(1);
          cur   <= nxt;
          idx   <= '0;
          st    <= limit_hit ? S_IDLE : S_FRD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sgd_engine.sv
module sgd_engine #(
  parameter int unsigned AW   = 32,
  parameter int unsigned LENW = 16,
  parameter int unsigned MAXW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_we,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [31:0]   mem_rdata,
  output logic          irq
);
  logic            busy_w, ev_desc_w, ev_chain_w, ptr_adv_w, start_w;
  logic            gie_w, dd_w, cd_w;
  logic [AW-1:0]   ptr_nxt_w, ptr_w;
  logic [MAXW-1:0] max_w;

  sgd_regs #(.AW(AW), .MAXW(MAXW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy_w),
    .ev_desc(ev_desc_w), .ev_chain(ev_chain_w), .ptr_adv(ptr_adv_w),
    .ptr_nxt(ptr_nxt_w), .start(start_w), .ptr_q(ptr_w), .max_q(max_w),
    .gie_q(gie_w), .dd_q(dd_w), .cd_q(cd_w), .irq(irq)
  );

  sgd_walker #(.AW(AW), .LENW(LENW), .MAXW(MAXW)) u_walk (
    .clk(clk), .rst(rst), .start(start_w), .ptr_q(ptr_w), .max_q(max_w),
    .busy(busy_w), .ev_desc(ev_desc_w), .ev_chain(ev_chain_w),
    .ptr_adv(ptr_adv_w), .ptr_nxt(ptr_nxt_w), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/sgd_engine_chk.sv
module sgd_engine_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          gie,
  input logic          dd,
  input logic          cd,
  input logic          busy,
  input logic          mem_req,
  input logic          ptr_adv,
  input logic [AW-1:0] ptr
);
  p_irq_needs_gie_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie));
  p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(dd || cd));
  p_end_sets_chain_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> cd);
  p_mem_when_busy_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  p_ptr_hold_busy_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && !ptr_adv) |=> $stable(ptr));
endmodule

bind sgd_engine sgd_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .gie(gie_w), .dd(dd_w), .cd(cd_w),
  .busy(busy_w), .mem_req(mem_req), .ptr_adv(ptr_adv_w), .ptr(ptr_w)
);

// File: tb/sgd_engine_test.sv
module sgd_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        irq;

  logic [31:0] mem [0:1023];
  logic [31:0] exp_a[$];
  logic [31:0] exp_d[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit quiet_irq = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sgd_engine uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .irq(irq)
  );

  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:2]];
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock reference: ordered write stream and interrupt gating
  always @(negedge clk)
    if (!rst) begin
      if (mem_req && mem_we) begin
        if (exp_a.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL R5 unexpected write actual=%h expected=none", mem_addr);
        end else begin
          chk("R4 R5 write address", mem_addr, exp_a.pop_front());
          chk("R4 R5 write data", mem_wdata, exp_d.pop_front());
        end
      end
      if (quiet_irq) chk("R9 irq gated off", {31'd0, irq}, 32'd0);
    end

  task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic put_desc(input int b, input int s, input int d, input int n,
                          input int ln, input int act, input int fl);
    mem[b/4] = s; mem[b/4+1] = d; mem[b/4+2] = n; mem[b/4+3] = ln;
    mem[b/4+4] = act; mem[b/4+5] = fl; mem[b/4+6] = 0; mem[b/4+7] = 0;
  endtask

  task automatic expect_desc(input int b, input int s, input int d, input int ln, input int fl);
    for (int i = 0; i < ln/4; i++) begin
      exp_a.push_back(d + 4*i); exp_d.push_back(mem[s/4 + i]);
    end
    exp_a.push_back(b + 16); exp_d.push_back(ln & ~3);
    exp_a.push_back(b + 20); exp_d.push_back(fl & ~1);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 3000; k++) begin
      reg_read(6'd0, v);
      if (!v[2]) break;
    end
  endtask

  task automatic finish_run(input string tag);
    chk({tag, " pending writes"}, exp_a.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog actual=running expected=idle");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 + i * 32'h0001_0203;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    reg_read(6'd0, v);  chk("R1 status after reset", v, 0);
    reg_read(6'd16, v); chk("R1 control after reset", v, 0);
    reg_read(6'd32, v); chk("R1 pointer after reset", v, 0);
    chk("R1 irq after reset", {31'd0, irq}, 0);

    // R3 R4 R5 R6 R11: three owned descriptors (one empty) then a free one
    put_desc(32'h100, 32'h400, 32'h800, 32'h120, 12, 0, 32'h31);
    put_desc(32'h120, 32'h410, 32'h900, 32'h140, 0,  0, 32'h1);
    put_desc(32'h140, 32'h420, 32'h880, 32'h160, 8,  0, 32'h5);
    put_desc(32'h160, 32'h430, 32'h980, 32'h180, 4,  32'hDEAD, 32'h0);
    expect_desc(32'h100, 32'h400, 32'h800, 12, 32'h31);
    expect_desc(32'h120, 32'h410, 32'h900, 0,  32'h1);
    expect_desc(32'h140, 32'h420, 32'h880, 8,  32'h5);
    reg_write(6'd32, 32'h100);
    reg_write(6'd16, 32'hF);
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run("R6");
    reg_read(6'd0, v);  chk("R8 R6 status after chain", v, 32'h3);
    reg_read(6'd32, v); chk("R6 R11 pointer at free descriptor", v, 32'h160);
    chk("R9 irq with enables", {31'd0, irq}, 1);
    chk("R6 free descriptor untouched", mem[(32'h160+16)/4], 32'hDEAD);
    chk("R4 copied word", mem[32'h808/4], mem[32'h408/4]);
    chk("R5 flags kept bits", mem[(32'h100+20)/4], 32'h30);
    reg_read(6'd16, v); chk("R2 control readback", v, 32'hF);

    // R8 R9 plain clear
    reg_write(6'd0, 32'h3);
    repeat (3) @(negedge clk);
    reg_read(6'd0, v); chk("R8 status cleared", v, 0);
    chk("R9 irq drops after clear", {31'd0, irq}, 0);

    // R9 global enable off, R10 pointer write while busy
    put_desc(32'h200, 32'h440, 32'hA00, 32'h220, 4, 0, 32'h1);
    put_desc(32'h220, 32'h440, 32'hA80, 32'h240, 4, 0, 32'h0);
    expect_desc(32'h200, 32'h440, 32'hA00, 4, 32'h1);
    reg_write(6'd32, 32'h200);
    quiet_irq = 1'b1;
    reg_write(6'd16, 32'h7);
    reg_write(6'd32, 32'h300);
    wait_idle();
    repeat (3) @(negedge clk);
    quiet_irq = 1'b0;
    finish_run("R9");
    reg_read(6'd0, v);  chk("R9 flags set without global enable", v, 32'h3);
    reg_read(6'd32, v); chk("R10 pointer write ignored while busy", v, 32'h220);
    reg_write(6'd16, 32'hE);
    repeat (3) @(negedge clk);
    chk("R9 irq after global enable", {31'd0, irq}, 1);
    reg_write(6'd0, 32'h3);

    // R7 descriptor limit of 2
    put_desc(32'h300, 32'h450, 32'hB00, 32'h320, 4, 0, 32'h1);
    put_desc(32'h320, 32'h460, 32'hB40, 32'h340, 4, 0, 32'h1);
    put_desc(32'h340, 32'h470, 32'hB80, 32'h360, 4, 0, 32'h1);
    put_desc(32'h360, 32'h470, 32'hBC0, 32'h380, 4, 0, 32'h0);
    expect_desc(32'h300, 32'h450, 32'hB00, 4, 32'h1);
    expect_desc(32'h320, 32'h460, 32'hB40, 4, 32'h1);
    reg_write(6'd32, 32'h300);
    reg_write(6'd16, 32'h20F);
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run("R7");
    reg_read(6'd0, v);  chk("R7 status after limit", v, 32'h3);
    reg_read(6'd32, v); chk("R7 pointer after limit", v, 32'h340);
    chk("R7 third descriptor still owned", mem[(32'h340+20)/4], 32'h1);
    reg_write(6'd0, 32'h3);

    // R8 clear in the same cycle as descriptor completion
    put_desc(32'h180, 32'h480, 32'hC00, 32'h1A0, 4, 0, 32'h1);
    put_desc(32'h1A0, 32'h480, 32'hC40, 32'h1C0, 4, 0, 32'h0);
    expect_desc(32'h180, 32'h480, 32'hC00, 4, 32'h1);
    reg_write(6'd32, 32'h180);
    reg_write(6'd16, 32'hB);
    @(negedge clk);
    for (int k = 0; k < 500; k++) begin
      if (mem_req && mem_we && mem_addr == 32'h194) break;
      @(negedge clk);
    end
    reg_we = 1'b1; reg_addr = 6'd0; reg_wdata = 32'h1;
    @(negedge clk); reg_we = 1'b0;
    wait_idle();
    repeat (3) @(negedge clk);
    finish_run("R8");
    reg_read(6'd0, v); chk("R8 set wins over same-cycle clear", v, 32'h3);
    chk("R9 irq from descriptor flag", {31'd0, irq}, 1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule